// File: doc/BRIEF.md
# Single-Channel Pulse-Width Modulator with Duty Queue

This block drives one pulse-width modulated output from a set of software-visible registers. A prescaler divides the input clock. The divided ticks advance a period counter that runs through the programmed period value plus two ticks and then wraps. Duty values are written into a four-entry queue. One value is taken from the queue when the generator is enabled and again each time a period wraps. The output is active from the start of a period until the counter reaches the current duty value. A control bit flips the output polarity.

Software can keep up to four future duty values queued and can read the fill level and a sticky drop flag. A self-clearing reset bit empties the queue and returns every register to its default. The register port is a plain single-cycle write and combinational read. It has no back-pressure: the block accepts a write in every cycle, and a duty write that finds the queue full is discarded and flagged, never stalled. The clock-select and low-power enable fields are stored and read back only.

Top module: `pwm_gen`

## Requirements
- R1: After reset the output is 0 and every register reads 0. Register addresses are: 0 control, 1 status, 2 duty queue (a read returns the duty value in use), 3 period.
- R2: A write to address 2 pushes bits 15:0 into a 4-entry queue. Status bits 2:0 give the number of queued entries (0 to 4).
- R3: A duty write while the queue holds 4 entries is dropped, even if an entry is taken in the same cycle, and it sets status bit 4. That bit stays set until a soft reset or a hard reset.
- R4: Control bits 15:4 hold the clock divide ratio minus one. The period counter advances once per divided tick.
- R5: The counter counts divided ticks from 0 up to the period register value plus 1, so a period lasts the period value plus 2 ticks. When the counter is at or beyond that limit on a tick, it wraps to 0.
- R6: An entry is taken from the queue when control bit 0 goes from 0 to 1, and at each wrap. This also zeroes the counter and the prescaler. If the queue is empty, the previous duty value is kept.
- R7: While enabled, the output is active when the counter is below the duty value. A duty value of 0 gives a constantly inactive output. A duty value of at least the period value plus 2 gives a constantly active output.
- R8: Control bit 18 inverts the output. While control bit 0 is 0, the output sits at its inactive level, which is the value of bit 18.
- R9: Writing control with bit 3 set makes control read 8 for one cycle. Writes in that cycle are ignored. After it, all registers, the queue and the drop flag are 0.
- R10: Control bits 17:16 and 24:22 are stored and read back but do not change the output. Unlisted control bits read 0.
- R11: Writing 0 to control holds the output inactive and freezes the counter until the next enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for rd_addr |
| pwm_out | output | 1 | Modulated output |

## Verification
The hardest situation to reach from the ports is a queue that is already full at the same edge where a period wraps and takes an entry. This is where the rule that a write seeing four entries is dropped becomes visible. The stimulus keeps the generator running with a very short period and zero prescale, fills the queue, and then keeps writing duty values in successive cycles so that some writes land on a wrap edge. Every write is compared against a queue model in the bench. A soft reset is also issued with a write placed in the very next cycle, which shows that the pending cycle ignores writes.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_DUTY = 2'd2,
    REG_PER  = 2'd3
  } reg_sel_e;

  localparam int CB_EN    = 0;
  localparam int CB_SRST  = 3;
  localparam int CB_PSLO  = 4;
  localparam int CB_PSHI  = 15;
  localparam int CB_INV   = 18;
  localparam int SB_OVF   = 4;
  localparam logic [31:0] CTRL_KEEP = 32'h01C7_FFF1;
  localparam logic [31:0] CTRL_SRST_VAL = 32'h0000_0008;
endpackage

// File: rtl/pwm_fifo.sv
module pwm_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic [CW-1:0] fill,
  output logic          dropped
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rp, wp;
  logic full, empty, do_push, do_pop;

  assign full    = (fill == CW'(DEPTH));
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dropped = push && full;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rp   <= '0;
      wp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !do_push) fill <= fill - 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) mem[i] <= '0;
        else if (do_push && wp == AW'(i)) mem[i] <= din;
      end
    end
  endgenerate
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int PSW = 12,
  parameter int PW  = 16,
  localparam int CNTW = PW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            run,
  input  logic            start,
  input  logic [PSW-1:0]  div_m1,
  input  logic [PW-1:0]   per,
  output logic [CNTW-1:0] cnt,
  output logic            wrap
);
  logic [PSW-1:0]  pre;
  logic            tick;
  logic [CNTW-1:0] limit;

  assign tick  = run && (pre == div_m1);
  assign limit = {1'b0, per} + CNTW'(1);
  assign wrap  = tick && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr || start) begin
      pre <= '0;
      cnt <= '0;
    end else if (run) begin
      if (tick) begin
        pre <= '0;
        cnt <= wrap ? '0 : cnt + 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm_gen.sv
module pwm_gen
  import pwm_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  parameter int PSW   = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        pwm_out
);
  logic [31:0]   ctrl_q;
  logic [DW-1:0] per_q, duty_q, fifo_dout;
  logic [CW-1:0] fifo_cnt;
  logic          srst_pend, ovf_q, wr_ok, start, pop, wrap, dropped, active;
  logic [DW:0]   cnt;

  assign wr_ok = wr_en && !srst_pend;
  assign start = wr_ok && (wr_addr == REG_CTRL) && wr_data[CB_EN]
                 && !wr_data[CB_SRST] && !ctrl_q[CB_EN];
  assign pop   = wrap || start;

  pwm_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .clr(srst_pend),
    .push(wr_ok && wr_addr == REG_DUTY), .din(wr_data[DW-1:0]),
    .pop(pop), .dout(fifo_dout), .fill(fifo_cnt), .dropped(dropped)
  );

  pwm_timebase #(.PSW(PSW), .PW(DW)) u_tb (
    .clk(clk), .rst(rst), .clr(srst_pend), .run(ctrl_q[CB_EN]),
    .start(start), .div_m1(ctrl_q[CB_PSLO +: PSW]), .per(per_q),
    .cnt(cnt), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst || srst_pend) begin
      ctrl_q    <= '0;
      per_q     <= '0;
      duty_q    <= '0;
      ovf_q     <= 1'b0;
      srst_pend <= 1'b0;
    end else begin
      if (pop && fifo_cnt != '0) duty_q <= fifo_dout;
      if (dropped) ovf_q <= 1'b1;
      if (wr_ok && wr_addr == REG_PER) per_q <= wr_data[DW-1:0];
      if (wr_ok && wr_addr == REG_CTRL) begin
        if (wr_data[CB_SRST]) begin
          ctrl_q    <= CTRL_SRST_VAL;
          srst_pend <= 1'b1;
        end else begin
          ctrl_q    <= wr_data & CTRL_KEEP;
        end
      end
    end
  end

  assign active  = (cnt < {1'b0, duty_q});
  assign pwm_out = ctrl_q[CB_EN] ? (active ^ ctrl_q[CB_INV]) : ctrl_q[CB_INV];

  always_comb begin
    rd_data = '0;
    unique case (reg_sel_e'(rd_addr))
      REG_CTRL: rd_data = ctrl_q;
      REG_STAT: begin
        rd_data[CW-1:0]  = fifo_cnt;
        rd_data[SB_OVF]  = ovf_q;
      end
      REG_DUTY: rd_data[DW-1:0] = duty_q;
      REG_PER:  rd_data[DW-1:0] = per_q;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwm_gen_chk.sv
module pwm_gen_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          inv,
  input logic          pwm_out,
  input logic [CW-1:0] fill,
  input logic          ovf,
  input logic          srst
);
  a_r2_fill_bound: assert property (@(posedge clk) disable iff (rst)
    int'(fill) <= DEPTH);

  a_r2_fill_step: assert property (@(posedge clk) disable iff (rst)
    !srst |=> (fill == $past(fill)) || (int'(fill) == int'($past(fill)) + 1)
              || (int'(fill) + 1 == int'($past(fill))));

  a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    (ovf && !srst) |=> ovf);

  a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
    !run |-> (pwm_out == inv));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (rst)
    srst |=> (fill == '0) && !ovf && !srst && !run);
endmodule

bind pwm_gen pwm_gen_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl_q[0]), .inv(ctrl_q[18]),
  .pwm_out(pwm_out), .fill(fifo_cnt), .ovf(ovf_q), .srst(srst_pend)
);

// File: tb/sim_pwm_gen.sv
module sim_pwm_gen;
  logic clk = 0, rst = 1, wv = 0;
  logic [1:0] wa = 0, ra = 0;
  logic [31:0] wd = 0, rd;
  logic pout;
  int errors = 0, checks = 0;
  bit done = 0;
  string req = "R1";

  always #4 clk = ~clk;

  pwm_gen u0 (.clk(clk), .rst(rst), .wr_en(wv), .wr_addr(wa), .wr_data(wd),
              .rd_addr(ra), .rd_data(rd), .pwm_out(pout));

  // behavioural reference
  int q[$];
  logic [31:0] m_ctrl;
  int m_per, m_cur, m_cnt, m_pre;
  bit m_ovf, m_sp;

  always @(posedge clk) begin
    if (rst || m_sp) begin
      q.delete(); m_ctrl = 0; m_per = 0; m_cur = 0; m_cnt = 0; m_pre = 0;
      m_ovf = 0; m_sp = 0;
    end else begin
      int osz, presc;
      bit en, pop;
      osz = q.size(); en = m_ctrl[0]; presc = int'(m_ctrl[15:4]); pop = 0;
      if (en) begin
        if (m_pre == presc) begin
          m_pre = 0;
          if (m_cnt >= m_per + 1) begin m_cnt = 0; pop = 1; end
          else m_cnt++;
        end else m_pre++;
      end
      if (wv && wa == 0 && wd[0] && !wd[3] && !en) begin
        m_cnt = 0; m_pre = 0; pop = 1;
      end
      if (pop && q.size() > 0) m_cur = q.pop_front();
      if (wv && wa == 2) begin
        if (osz < 4) q.push_back(int'(wd[15:0])); else m_ovf = 1;
      end
      if (wv && wa == 0) begin
        if (wd[3]) begin m_ctrl = 32'h8; m_sp = 1; end
        else m_ctrl = wd & 32'h01C7_FFF1;
      end
      if (wv && wa == 3) m_per = int'(wd[15:0]);
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return {27'd0, m_ovf, 1'b0, 3'(q.size())};
      2'd2: return 32'(m_cur);
      default: return 32'(m_per);
    endcase
  endfunction

  function automatic logic exp_out();
    logic act;
    act = (m_cnt < m_cur);
    return m_ctrl[0] ? (act ^ m_ctrl[18]) : m_ctrl[18];
  endfunction

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks += 2;
      if (pout !== exp_out()) begin
        errors++;
        $display("FAIL %s pwm_out actual=%b expected=%b t=%0t", req, pout, exp_out(), $time);
      end
      if (rd !== exp_rd(ra)) begin
        errors++;
        $display("FAIL %s rd_data[%0d] actual=%h expected=%h t=%0t", req, ra, rd, exp_rd(ra), $time);
      end
    end
  end

  always @(posedge clk) begin
    #2 ra <= ra + 2'd1;
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2; wv = 1; wa = a; wd = d;
    @(posedge clk); #2; wv = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    idle(3); #2 rst = 0;
    req = "R1"; idle(8);
    req = "R2"; wr(2, 3); wr(2, 5); idle(4);
    req = "R3"; wr(2, 7); wr(2, 9); wr(2, 11); idle(4);
    req = "R10"; wr(0, 32'hFFC3_0006); idle(6);
    req = "R5"; wr(3, 4);
    req = "R4"; wr(0, 32'h0000_0011); idle(40);
    req = "R6"; idle(60);
    req = "R7"; wr(2, 0); idle(40); wr(2, 200); idle(40);
    req = "R8"; wr(0, 32'h0004_0011); wr(2, 2); idle(40);
    req = "R11"; wr(0, 0); idle(20);
    req = "R9"; wr(2, 1); wr(2, 2);
    @(posedge clk); #2; wv = 1; wa = 0; wd = 32'h8;
    @(posedge clk); #2; wa = 2; wd = 32'h5;
    @(posedge clk); #2; wv = 0; idle(8);
    req = "R3"; wr(3, 0); wr(0, 32'h1);
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #2; wv = 1; wa = 2; wd = 32'(i % 3);
    end
    @(posedge clk); #2; wv = 0; idle(30);
    req = "R5"; wr(3, 1); wr(2, 2); wr(0, 0); wr(0, 32'h21); idle(40);
    finish_run();
  end
endmodule